// File: doc/BRIEF.md
# Port-to-Memory Block Input Sequencer

This block moves data from the I/O space into a memory buffer. A single start pulse hands it a 16-bit port number, a 64-bit buffer pointer, a direction bit, an element size and, for block moves, a repeat flag with a 64-bit element count. For each element it issues one I/O read, forwards the returned data in one memory write at the current pointer, and then moves the pointer by the element size. A repeated move runs until the count reaches zero. A single move transfers exactly one element and leaves the count untouched.

When the requester runs with less privilege than the I/O level, or in virtual mode, the block first asks an external checker whether the port may be touched. It asks once, before any bus traffic. A refusal ends the operation with a fault and nothing is transferred. Completion, with or without a fault, is reported by a one-cycle done pulse. The final pointer and count can be read on dedicated outputs.

Top module: `pio_block_input`

## Requirements
- R1: While reset is asserted, and in idle after it, `busy`, `done`, `fault`, `perm_req`, `io_rd_req` and `mem_wr_req` are all low.
- R2: Each element runs in a fixed order. First, `io_rd_req` stays high until `io_rd_ack`. Then `mem_wr_req` stays high with stable `mem_addr` (the current pointer) and `mem_data` (the data captured with the acknowledge) until `mem_wr_ack`. The two requests are never high together.
- R3: After each element the pointer moves by the element byte count: up when `dir_down` is 0, down when it is 1. The arithmetic is modulo 2^64, so it wraps at both ends.
- R4: `size_sel` sets the element size: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, and 3 (a 64-bit request) is also 4 bytes. `io_bytes` and `mem_bytes` both carry this byte count.
- R5: With `rep_en`=1, exactly `count_in` elements are moved, the count drops by one per element and ends at 0. With `rep_en`=0, one element is moved whatever `count_in` holds, and `count_out` keeps the loaded value.
- R6: With `rep_en`=1 and `count_in`=0, `done` rises on the first clock after start. No permission request and no bus request is made, and the pointer stays as loaded.
- R7: A permission request is made exactly once, before the first element, when `priv_above` or `virt_mode` is high at start. Otherwise none is made. `perm_req` is never high together with a bus request.
- R8: If the permission answer has `perm_ok`=0, the block raises `done` with `fault`=1, makes no I/O read or memory write, and leaves the pointer as loaded.
- R9: `done` is a one-cycle pulse that ends the operation. `fault` is high only together with `done`. `busy` is high from the cycle after an accepted start through the `done` cycle.
- R10: `io_addr` carries the port number given at start on every I/O read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| port_addr | input | 16 | I/O port number |
| buf_ptr | input | 64 | Initial buffer pointer |
| dir_down | input | 1 | 1 = pointer moves down |
| size_sel | input | 2 | Element size code (see R4) |
| rep_en | input | 1 | Repeat until count is exhausted |
| count_in | input | 64 | Element count for repeat |
| priv_above | input | 1 | Requester less privileged than I/O level |
| virt_mode | input | 1 | Virtual mode active |
| perm_req | output | 1 | Permission query |
| perm_ack | input | 1 | Permission answer valid |
| perm_ok | input | 1 | Access allowed |
| io_rd_req | output | 1 | I/O read request |
| io_addr | output | 16 | I/O read port |
| io_bytes | output | 3 | I/O read width in bytes |
| io_rd_ack | input | 1 | I/O read done, data valid |
| io_rd_data | input | 32 | I/O read data |
| mem_wr_req | output | 1 | Memory write request |
| mem_addr | output | 64 | Memory write address |
| mem_data | output | 32 | Memory write data |
| mem_bytes | output | 3 | Memory write width in bytes |
| mem_wr_ack | input | 1 | Memory write done |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished (pulse) |
| fault | output | 1 | Protection fault, with done |
| ptr_out | output | 64 | Current pointer |
| count_out | output | 64 | Current count |

## Verification
The bench targets these corner cases:
- A repeat with a zero count. A design that tested for exhaustion only after the first element would move one element, or wrap the count to all ones and never stop.
- A single move with a zero count. A design that mixed up the two modes would skip the element or alter the count.
- Pointers that cross zero in both directions, and downward word moves. A wrong sign or a step that ignored the size would put later writes at the wrong addresses.
- The 64-bit size request. A design that did not fold it to 4 bytes would report 8-byte or 1-byte widths and step by the wrong amount.
- A permission refusal. A leaky design would still issue a read, move the pointer, or report done without a fault.
- A privileged, non-virtual caller. A design that queried the checker anyway would show an extra permission request.
- Slow acknowledges on every handshake. These expose requests that drop early, and data that changes before the write is accepted.

// File: rtl/pio_pkg.sv
package pio_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_READ,
    ST_WRITE,
    ST_STEP,
    ST_FIN
  } seq_state_t;

  // size code to byte count; the 64-bit request folds to 4 bytes
  function automatic logic [2:0] elem_bytes(input logic [1:0] sel);
    case (sel)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/pio_size_map.sv
module pio_size_map
  import pio_pkg::*;
#(
  parameter int BW = 3
) (
  input  logic [1:0]    size_sel,
  output logic [BW-1:0] bytes
);

  always_comb begin
    bytes = BW'(elem_bytes(size_sel));
  end

endmodule

// File: rtl/pio_addr_step.sv
module pio_addr_step #(
  parameter int AW = 64,
  parameter int CW = 64,
  parameter int BW = 3
) (
  input  logic [AW-1:0] ptr,
  input  logic [CW-1:0] cnt,
  input  logic [BW-1:0] bytes,
  input  logic          down,
  input  logic          rep,
  output logic [AW-1:0] ptr_nxt,
  output logic [CW-1:0] cnt_nxt,
  output logic          last
);

  function automatic logic [AW-1:0] advance(input logic [AW-1:0] p,
                                            input logic [BW-1:0] b,
                                            input logic          dn);
    logic [AW-1:0] delta;
    delta = AW'(b);
    return dn ? (p - delta) : (p + delta);
  endfunction

  function automatic logic [CW-1:0] consume(input logic [CW-1:0] c,
                                            input logic          r);
    return r ? (c - CW'(1)) : c;
  endfunction

  always_comb begin
    ptr_nxt = advance(ptr, bytes, down);
    cnt_nxt = consume(cnt, rep);
    last    = !rep || (cnt_nxt == '0);
  end

endmodule

// File: rtl/pio_seq_ctrl.sv
module pio_seq_ctrl
  import pio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       empty_req,
  input  logic       need_perm,
  input  logic       perm_ack,
  input  logic       perm_ok,
  input  logic       rd_ack,
  input  logic       wr_ack,
  input  logic       last,
  output seq_state_t state,
  output logic       load_evt,
  output logic       capture_evt,
  output logic       step_evt,
  output logic       done,
  output logic       fault
);

  seq_state_t state_nxt;
  logic       fault_q;
  logic       deny_evt;

  assign load_evt    = (state == ST_IDLE) && start;
  assign capture_evt = (state == ST_READ) && rd_ack;
  assign step_evt    = (state == ST_STEP);
  assign deny_evt    = (state == ST_CHECK) && perm_ack && !perm_ok;

  always_comb begin
    state_nxt = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          if (empty_req)      state_nxt = ST_FIN;
          else if (need_perm) state_nxt = ST_CHECK;
          else                state_nxt = ST_READ;
        end
      end
      ST_CHECK: begin
        if (perm_ack) state_nxt = perm_ok ? ST_READ : ST_FIN;
      end
      ST_READ:  if (rd_ack) state_nxt = ST_WRITE;
      ST_WRITE: if (wr_ack) state_nxt = ST_STEP;
      ST_STEP:  state_nxt = last ? ST_FIN : ST_READ;
      ST_FIN:   state_nxt = ST_IDLE;
      default:  state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      fault_q <= 1'b0;
    end else begin
      state <= state_nxt;
      if (load_evt)      fault_q <= 1'b0;
      else if (deny_evt) fault_q <= 1'b1;
    end
  end

  assign done  = (state == ST_FIN);
  assign fault = done && fault_q;

endmodule

// File: rtl/pio_block_input.sv
module pio_block_input
  import pio_pkg::*;
#(
  parameter int AW = 64,
  parameter int CW = 64,
  parameter int PW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [PW-1:0] port_addr,
  input  logic [AW-1:0] buf_ptr,
  input  logic          dir_down,
  input  logic [1:0]    size_sel,
  input  logic          rep_en,
  input  logic [CW-1:0] count_in,
  input  logic          priv_above,
  input  logic          virt_mode,
  output logic          perm_req,
  input  logic          perm_ack,
  input  logic          perm_ok,
  output logic          io_rd_req,
  output logic [PW-1:0] io_addr,
  output logic [2:0]    io_bytes,
  input  logic          io_rd_ack,
  input  logic [DW-1:0] io_rd_data,
  output logic          mem_wr_req,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic [2:0]    mem_bytes,
  input  logic          mem_wr_ack,
  output logic          busy,
  output logic          done,
  output logic          fault,
  output logic [AW-1:0] ptr_out,
  output logic [CW-1:0] count_out
);

  localparam int BW = 3;

  seq_state_t    state;
  logic          load_evt, capture_evt, step_evt, last;
  logic          empty_req, need_perm;
  logic [PW-1:0] port_q;
  logic [AW-1:0] ptr_q, ptr_nxt;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic [DW-1:0] data_q;
  logic [1:0]    sel_q;
  logic          dir_q, rep_q;
  logic [BW-1:0] bytes_w;

  assign empty_req = rep_en && (count_in == '0);
  assign need_perm = priv_above || virt_mode;

  pio_seq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .empty_req   (empty_req),
    .need_perm   (need_perm),
    .perm_ack    (perm_ack),
    .perm_ok     (perm_ok),
    .rd_ack      (io_rd_ack),
    .wr_ack      (mem_wr_ack),
    .last        (last),
    .state       (state),
    .load_evt    (load_evt),
    .capture_evt (capture_evt),
    .step_evt    (step_evt),
    .done        (done),
    .fault       (fault)
  );

  pio_size_map #(.BW(BW)) u_size (
    .size_sel (sel_q),
    .bytes    (bytes_w)
  );

  pio_addr_step #(.AW(AW), .CW(CW), .BW(BW)) u_step (
    .ptr     (ptr_q),
    .cnt     (cnt_q),
    .bytes   (bytes_w),
    .down    (dir_q),
    .rep     (rep_q),
    .ptr_nxt (ptr_nxt),
    .cnt_nxt (cnt_nxt),
    .last    (last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_q <= '0;
      ptr_q  <= '0;
      cnt_q  <= '0;
      data_q <= '0;
      sel_q  <= '0;
      dir_q  <= 1'b0;
      rep_q  <= 1'b0;
    end else begin
      if (load_evt) begin
        port_q <= port_addr;
        ptr_q  <= buf_ptr;
        cnt_q  <= count_in;
        sel_q  <= size_sel;
        dir_q  <= dir_down;
        rep_q  <= rep_en;
      end
      if (capture_evt) data_q <= io_rd_data;
      if (step_evt) begin
        ptr_q <= ptr_nxt;
        cnt_q <= cnt_nxt;
      end
    end
  end

  assign perm_req   = (state == ST_CHECK);
  assign io_rd_req  = (state == ST_READ);
  assign mem_wr_req = (state == ST_WRITE);
  assign io_addr    = port_q;
  assign io_bytes   = bytes_w;
  assign mem_bytes  = bytes_w;
  assign mem_addr   = ptr_q;
  assign mem_data   = data_q;
  assign busy       = (state != ST_IDLE);
  assign ptr_out    = ptr_q;
  assign count_out  = cnt_q;

endmodule

// File: rtl/pio_block_input_chk.sv
module pio_block_input_chk #(
  parameter int AW = 64,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          perm_req,
  input logic          io_rd_req,
  input logic          io_rd_ack,
  input logic          mem_wr_req,
  input logic          mem_wr_ack,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_data,
  input logic [2:0]    io_bytes,
  input logic [2:0]    mem_bytes,
  input logic          done,
  input logic          fault,
  input logic          busy,
  input logic [AW-1:0] ptr_out,
  input logic          step_evt,
  input logic          dir_q
);

  // R1: no request without an operation in progress
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!io_rd_req && !mem_wr_req && !perm_req && !done));

  p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd_req && mem_wr_req));

  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd_req && !io_rd_ack) |=> io_rd_req);

  p_wr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_wr_ack) |=>
      (mem_wr_req && $stable(mem_addr) && $stable(mem_data)));

  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> (ptr_out == ($past(dir_q)
                   ? ($past(ptr_out) - AW'($past(io_bytes)))
                   : ($past(ptr_out) + AW'($past(io_bytes))))));

  p_size_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((io_bytes == 3'd1 || io_bytes == 3'd2 || io_bytes == 3'd4)
              && io_bytes == mem_bytes));

  p_perm_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
    perm_req |-> (!io_rd_req && !mem_wr_req));

  p_fault_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

endmodule

bind pio_block_input pio_block_input_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .perm_req   (perm_req),
  .io_rd_req  (io_rd_req),
  .io_rd_ack  (io_rd_ack),
  .mem_wr_req (mem_wr_req),
  .mem_wr_ack (mem_wr_ack),
  .mem_addr   (mem_addr),
  .mem_data   (mem_data),
  .io_bytes   (io_bytes),
  .mem_bytes  (mem_bytes),
  .done       (done),
  .fault      (fault),
  .busy       (busy),
  .ptr_out    (ptr_out),
  .step_evt   (step_evt),
  .dir_q      (dir_q)
);

// File: tb/pio_block_input_tb.sv
module pio_block_input_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] port_addr;
  logic [63:0] buf_ptr;
  logic        dir_down;
  logic [1:0]  size_sel;
  logic        rep_en;
  logic [63:0] count_in;
  logic        priv_above, virt_mode;
  logic        perm_req, perm_ack, perm_ok;
  logic        io_rd_req, io_rd_ack;
  logic [15:0] io_addr;
  logic [2:0]  io_bytes;
  logic [31:0] io_rd_data;
  logic        mem_wr_req, mem_wr_ack;
  logic [63:0] mem_addr;
  logic [31:0] mem_data;
  logic [2:0]  mem_bytes;
  logic        busy, done, fault;
  logic [63:0] ptr_out, count_out;

  always #4 clk = ~clk;

  pio_block_input u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .port_addr(port_addr),
    .buf_ptr(buf_ptr), .dir_down(dir_down), .size_sel(size_sel),
    .rep_en(rep_en), .count_in(count_in), .priv_above(priv_above),
    .virt_mode(virt_mode), .perm_req(perm_req), .perm_ack(perm_ack),
    .perm_ok(perm_ok), .io_rd_req(io_rd_req), .io_addr(io_addr),
    .io_bytes(io_bytes), .io_rd_ack(io_rd_ack), .io_rd_data(io_rd_data),
    .mem_wr_req(mem_wr_req), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_bytes(mem_bytes), .mem_wr_ack(mem_wr_ack), .busy(busy),
    .done(done), .fault(fault), .ptr_out(ptr_out), .count_out(count_out)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  // responder state and logs
  int rd_lat = 0, wr_lat = 0, pm_lat = 0;
  bit grant = 1;
  int n_rd, n_wr, n_perm, n_overlap;
  int rd_wait, wr_wait, pm_wait;
  logic [15:0] log_port [8];
  logic [2:0]  log_rb   [8];
  logic [63:0] log_wa   [8];
  logic [31:0] log_wd   [8];
  logic [2:0]  log_wb   [8];
  logic        got_fault;
  int          wait_cycles;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    perm_ack = 0; perm_ok = 0; io_rd_ack = 0; io_rd_data = '0; mem_wr_ack = 0;
    rd_wait = 0; wr_wait = 0; pm_wait = 0;
    forever begin
      @(negedge clk);
      perm_ack = 0; io_rd_ack = 0; mem_wr_ack = 0;
      if (io_rd_req && mem_wr_req) n_overlap++;
      if (perm_req) begin
        if (pm_wait < pm_lat) pm_wait++;
        else begin
          pm_wait = 0; perm_ack = 1; perm_ok = grant; n_perm++;
        end
      end
      if (io_rd_req) begin
        if (rd_wait < rd_lat) rd_wait++;
        else begin
          rd_wait = 0; io_rd_ack = 1;
          io_rd_data = {16'(n_rd), io_addr};
          if (n_rd < 8) begin log_port[n_rd] = io_addr; log_rb[n_rd] = io_bytes; end
          n_rd++;
        end
      end
      if (mem_wr_req) begin
        if (wr_wait < wr_lat) wr_wait++;
        else begin
          wr_wait = 0; mem_wr_ack = 1;
          if (n_wr < 8) begin
            log_wa[n_wr] = mem_addr; log_wd[n_wr] = mem_data; log_wb[n_wr] = mem_bytes;
          end
          n_wr++;
        end
      end
    end
  end

  function automatic logic [63:0] exp_addr(input logic [63:0] base, input int k,
                                           input int nb, input bit dn);
    logic [63:0] off;
    off = 64'(k) * 64'(nb);
    if (dn) return base - off;
    return base + off;
  endfunction

  task automatic run_op(input logic [15:0] p, input logic [63:0] b, input bit dn,
                        input logic [1:0] s, input bit rp, input logic [63:0] c,
                        input bit pa, input bit vm);
    n_rd = 0; n_wr = 0; n_perm = 0; n_overlap = 0;
    @(negedge clk);
    port_addr = p; buf_ptr = b; dir_down = dn; size_sel = s; rep_en = rp;
    count_in = c; priv_above = pa; virt_mode = vm; start = 1;
    @(negedge clk);
    start = 0;
    chk("R9", "busy after start", 64'(busy), 64'd1);
    wait_cycles = 0;
    while (!done && wait_cycles < 400) begin
      @(negedge clk);
      wait_cycles++;
    end
    chk("R9", "done seen", 64'(done), 64'd1);
    got_fault = fault;
    @(negedge clk);
    chk("R9", "done one cycle", 64'(done), 64'd0);
    chk("R9", "idle after done", 64'(busy), 64'd0);
    chk("R2", "no overlap", 64'(n_overlap), 64'd0);
  endtask

  task automatic check_elems(input logic [15:0] p, input logic [63:0] b, input bit dn,
                             input int nb, input int n);
    chk("R5", "reads", 64'(n_rd), 64'(n));
    chk("R5", "writes", 64'(n_wr), 64'(n));
    for (int k = 0; k < n && k < 8; k++) begin
      chk("R10", "port", 64'(log_port[k]), 64'(p));
      chk("R4", "io bytes", 64'(log_rb[k]), 64'(nb));
      chk("R4", "mem bytes", 64'(log_wb[k]), 64'(nb));
      chk("R3", "write addr", log_wa[k], exp_addr(b, k, nb, dn));
      chk("R2", "write data", 64'(log_wd[k]), 64'({16'(k), p}));
    end
  endtask

  task automatic t_reset;
    chk("R1", "busy", 64'(busy), 64'd0);
    chk("R1", "done", 64'(done), 64'd0);
    chk("R1", "fault", 64'(fault), 64'd0);
    chk("R1", "requests", 64'({perm_req, io_rd_req, mem_wr_req}), 64'd0);
  endtask

  task automatic t_single_byte_up;
    rd_lat = 0; wr_lat = 0;
    run_op(16'h03F8, 64'h1000, 0, 2'd0, 0, 64'd5, 0, 0);
    check_elems(16'h03F8, 64'h1000, 0, 1, 1);
    chk("R3", "ptr", ptr_out, 64'h1001);
    chk("R5", "count kept", count_out, 64'd5);
    chk("R9", "no fault", 64'(got_fault), 64'd0);
    chk("R7", "no perm query", 64'(n_perm), 64'd0);
  endtask

  task automatic t_rep_word_down;
    rd_lat = 2; wr_lat = 3;
    run_op(16'hFFFF, 64'h2000, 1, 2'd1, 1, 64'd3, 0, 0);
    check_elems(16'hFFFF, 64'h2000, 1, 2, 3);
    chk("R3", "ptr", ptr_out, 64'h1FFA);
    chk("R5", "count zero", count_out, 64'd0);
    rd_lat = 0; wr_lat = 0;
  endtask

  task automatic t_qword_folds;
    run_op(16'h0060, 64'h10, 0, 2'd3, 1, 64'd2, 0, 0);
    check_elems(16'h0060, 64'h10, 0, 4, 2);
    chk("R4", "ptr", ptr_out, 64'h18);
  endtask

  task automatic t_zero_count;
    run_op(16'h0070, 64'hABC0, 0, 2'd2, 1, 64'd0, 1, 1);
    chk("R6", "immediate", 64'(wait_cycles), 64'd0);
    chk("R6", "reads", 64'(n_rd), 64'd0);
    chk("R6", "writes", 64'(n_wr), 64'd0);
    chk("R6", "perm", 64'(n_perm), 64'd0);
    chk("R6", "ptr", ptr_out, 64'hABC0);
    chk("R6", "fault", 64'(got_fault), 64'd0);
  endtask

  task automatic t_single_zero_count;
    run_op(16'h0071, 64'h300, 1, 2'd0, 0, 64'd0, 0, 0);
    check_elems(16'h0071, 64'h300, 1, 1, 1);
    chk("R5", "count kept", count_out, 64'd0);
    chk("R3", "ptr", ptr_out, 64'h2FF);
  endtask

  task automatic t_perm_pass;
    grant = 1; pm_lat = 2;
    run_op(16'h0080, 64'h40, 0, 2'd2, 1, 64'd2, 1, 0);
    chk("R7", "one query", 64'(n_perm), 64'd1);
    check_elems(16'h0080, 64'h40, 0, 4, 2);
    chk("R7", "no fault", 64'(got_fault), 64'd0);
    pm_lat = 0;
  endtask

  task automatic t_perm_fail;
    grant = 0; pm_lat = 1;
    run_op(16'h0090, 64'h5000, 0, 2'd1, 1, 64'd4, 0, 1);
    chk("R8", "fault", 64'(got_fault), 64'd1);
    chk("R8", "one query", 64'(n_perm), 64'd1);
    chk("R8", "reads", 64'(n_rd), 64'd0);
    chk("R8", "writes", 64'(n_wr), 64'd0);
    chk("R8", "ptr", ptr_out, 64'h5000);
    grant = 1; pm_lat = 0;
  endtask

  task automatic t_wrap;
    run_op(16'h0001, 64'h0, 1, 2'd2, 0, 64'd9, 0, 0);
    check_elems(16'h0001, 64'h0, 1, 4, 1);
    chk("R3", "wrap down", ptr_out, 64'hFFFF_FFFF_FFFF_FFFC);
    run_op(16'h0002, 64'hFFFF_FFFF_FFFF_FFFF, 0, 2'd0, 1, 64'd2, 0, 0);
    check_elems(16'h0002, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 2);
    chk("R3", "wrap up", ptr_out, 64'h1);
    chk("R5", "count zero", count_out, 64'd0);
  endtask

  initial begin
    rst_n = 0; start = 0; port_addr = '0; buf_ptr = '0; dir_down = 0;
    size_sel = '0; rep_en = 0; count_in = '0; priv_above = 0; virt_mode = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single_byte_up();
    t_rep_word_down();
    t_qword_folds();
    t_zero_count();
    t_single_zero_count();
    t_perm_pass();
    t_perm_fail();
    t_wrap();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule